// File: doc/BRIEF.md
# Parallel Configuration Byte Receiver

This block sits on the target side of a byte-wide configuration port. A host drives a select strobe, a write strobe and an 8-bit data bus, all sampled on the rising edge of the configuration clock. Each accepted byte goes to an internal consumer over a valid/ready handshake. The consumer may stall. When it does, the receiver raises a BUSY line, and the host must keep the same byte on the bus until BUSY falls.

The receiver also polices the protocol. The level of the write strobe must not change across two consecutive edges on which the device is selected. If it does, the receiver aborts: it emits a one-cycle status pulse and refuses further bytes until the host deselects it.

Top module: `cfg_par_rx`

## Requirements
- R1: After reset, `out_valid` and `abort_pulse` are low, and `busy` equals the inverse of `snk_ready`.
- R2: On a rising edge where `cs_n`=0, `wr_n`=0 and `busy`=0, `din` is captured. From the next cycle it is offered on `out_data` with `out_valid`=1.
- R3: `busy` is 1 whenever a byte is held (`out_valid`=1) or `snk_ready`=0. A held byte is released on the edge where `out_valid` and `snk_ready` are both 1.
- R4: A write cycle on an edge where `busy`=1 is ignored. The held byte on `out_data` does not change, even if `din` changes.
- R5: The first rising edge after `busy` falls, with the strobes still asserted, captures the byte then on `din`.
- R6: If `cs_n` is 0 on two successive edges and `wr_n` differs between them, `abort_pulse` is 1 for exactly the following cycle. No byte is captured on that edge.
- R7: After an abort, write cycles capture nothing until an edge with `cs_n`=1 is seen. After that, writes are accepted again, and no further abort pulse is raised while the strobe stays illegal.
- R8: On edges with `cs_n`=1, nothing is captured and changes of `wr_n` never cause an abort. Deasserting `cs_n` and `wr_n` together ends a sequence without an abort.
- R9: While `out_valid`=1 and `snk_ready`=0, `out_valid` stays 1 and `out_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Device select, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Configuration data byte from host |
| busy | output | 1 | Flow control to host; high means the byte is not taken |
| abort_pulse | output | 1 | One-cycle pulse on a protocol abort |
| out_valid | output | 1 | A captured byte is offered to the consumer |
| out_data | output | 8 | Captured byte |
| snk_ready | input | 1 | Consumer can take the offered byte |

## Verification
The checker relies on inputs that change only between rising edges and on `snk_ready` being driven at all times. It does not require the host to hold `din` while busy, because the stability check concerns `out_data` only. The bench drives every input on the falling edge. It deliberately breaks the hold rule once, to show that the held byte is unaffected. It produces write-strobe flips under select only in the abort scenarios, so the pulse checks see isolated events.

// File: rtl/cfg_par_rx_pkg.sv
package cfg_par_rx_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic prev_sel;
        logic prev_wr;
        logic locked;
        logic pulse;
    } proto_st_t;
endpackage

// File: rtl/cfg_par_rx_proto.sv
module cfg_par_rx_proto
    import cfg_par_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic blocked,
    output logic abort_pulse
);
    proto_st_t st_d, st_q;
    logic      flip;

    always_comb begin
        st_d  = st_q;
        flip  = !cs_n && st_q.prev_sel && (wr_n != st_q.prev_wr) && !st_q.locked;
        st_d.pulse    = flip;
        st_d.prev_sel = !cs_n;
        st_d.prev_wr  = wr_n;
        if (cs_n)
            st_d.locked = 1'b0;
        else if (flip)
            st_d.locked = 1'b1;
        blocked = st_q.locked || flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{prev_sel: 1'b0, prev_wr: 1'b1, locked: 1'b0, pulse: 1'b0};
        else
            st_q <= st_d;
    end

    assign abort_pulse = st_q.pulse;
endmodule

// File: rtl/cfg_par_rx_hold.sv
module cfg_par_rx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] din,
    input  logic         snk_ready,
    output logic         busy,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        busy = st_q.full || !snk_ready;
        if (take && !busy) begin
            st_d.full = 1'b1;
            st_d.data = din;
        end else if (st_q.full && snk_ready) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.full;
    assign out_data  = st_q.data;
endmodule

// File: rtl/cfg_par_rx.sv
module cfg_par_rx
    import cfg_par_rx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         wr_n,
    input  logic [W-1:0] din,
    output logic         busy,
    output logic         abort_pulse,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         snk_ready
);
    logic blocked;
    logic take;

    cfg_par_rx_proto u_proto (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .wr_n        (wr_n),
        .blocked     (blocked),
        .abort_pulse (abort_pulse)
    );

    assign take = !cs_n && !wr_n && !blocked;

    cfg_par_rx_hold #(.W(W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .din       (din),
        .snk_ready (snk_ready),
        .busy      (busy),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/cfg_par_rx_chk.sv
module cfg_par_rx_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         busy,
    input logic         abort_pulse,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         snk_ready
);
    a_r3_busy_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    a_r3_busy_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !snk_ready |-> busy);

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !snk_ready) |=> (out_valid && $stable(out_data)));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    a_r8_no_capture_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !out_valid) |=> !out_valid);

    a_r6_no_capture_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_pulse && !$past(out_valid)) |-> !out_valid);
endmodule

bind cfg_par_rx cfg_par_rx_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .busy        (busy),
    .abort_pulse (abort_pulse),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .snk_ready   (snk_ready)
);

// File: tb/cfg_par_rx_bench.sv
module cfg_par_rx_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic       snk_ready = 1'b1;
    logic       busy, abort_pulse, out_valid;
    logic [7:0] out_data;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_par_rx u_cfg_par_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .wr_n        (wr_n),
        .din         (din),
        .busy        (busy),
        .abort_pulse (abort_pulse),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .snk_ready   (snk_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_byte(input logic [7:0] b);
        logic was_busy;
        cs_n = 1'b0; wr_n = 1'b0; din = b;
        do begin
            was_busy = busy;
            tick();
        end while (was_busy);
        chk("R2 valid", out_valid, 1);
        chk("R2 data", out_data, b);
    endtask

    task automatic t_reset();
        chk("R1 valid", out_valid, 0);
        chk("R1 abort", abort_pulse, 0);
        chk("R1 busy", busy, 0);
    endtask

    task automatic t_stream();
        snk_ready = 1'b1;
        put_byte(8'hA5);
        put_byte(8'h3C);
        put_byte(8'hFF);
        put_byte(8'h00);
        tick();
        chk("R3 released", out_valid, 0);
        cs_n = 1'b1; wr_n = 1'b1;
        tick();
        chk("R8 end no abort", abort_pulse, 0);
    endtask

    task automatic t_stall();
        snk_ready = 1'b0;
        cs_n = 1'b0; wr_n = 1'b0; din = 8'h11;
        tick();
        chk("R5 no take while not ready", out_valid, 0);
        chk("R3 busy not ready", busy, 1);
        tick();
        chk("R5 still none", out_valid, 0);
        snk_ready = 1'b1;
        tick();
        chk("R5 first edge after busy low", out_valid, 1);
        chk("R5 data", out_data, 8'h11);
        snk_ready = 1'b0;
        din = 8'h22;
        tick();
        chk("R4 busy held", busy, 1);
        chk("R4 held data", out_data, 8'h11);
        tick();
        chk("R9 still valid", out_valid, 1);
        chk("R4 held data 2", out_data, 8'h11);
        snk_ready = 1'b1;
        tick();
        chk("R3 released on handshake", out_valid, 0);
        chk("R3 busy low", busy, 0);
        tick();
        chk("R5 next byte taken", out_valid, 1);
        chk("R5 next data", out_data, 8'h22);
        chk("R8 no abort in stall", abort_pulse, 0);
        cs_n = 1'b1; wr_n = 1'b1;
        tick();
        tick();
    endtask

    task automatic t_abort_w2r();
        snk_ready = 1'b1;
        cs_n = 1'b0; wr_n = 1'b0; din = 8'h5A;
        tick();
        chk("R2 pre-abort byte", out_data, 8'h5A);
        wr_n = 1'b1;
        tick();
        chk("R6 pulse", abort_pulse, 1);
        chk("R6 consumed", out_valid, 0);
        wr_n = 1'b0; din = 8'h77;
        tick();
        chk("R6 pulse one cycle", abort_pulse, 0);
        chk("R7 refused", out_valid, 0);
        wr_n = 1'b1;
        tick();
        chk("R7 no second pulse", abort_pulse, 0);
        wr_n = 1'b0;
        tick();
        chk("R7 still refused", out_valid, 0);
        cs_n = 1'b1;
        tick();
        cs_n = 1'b0; wr_n = 1'b0; din = 8'h88;
        tick();
        chk("R7 resumed", out_valid, 1);
        chk("R7 resumed data", out_data, 8'h88);
        chk("R7 no abort on resume", abort_pulse, 0);
        cs_n = 1'b1; wr_n = 1'b1;
        tick();
    endtask

    task automatic t_abort_r2w();
        cs_n = 1'b0; wr_n = 1'b1; din = 8'h44;
        tick();
        chk("R8 read no capture", out_valid, 0);
        wr_n = 1'b0;
        tick();
        chk("R6 r2w pulse", abort_pulse, 1);
        chk("R6 r2w no capture", out_valid, 0);
        cs_n = 1'b1; wr_n = 1'b1;
        tick();
        chk("R6 r2w pulse ends", abort_pulse, 0);
    endtask

    task automatic t_deselected();
        cs_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            wr_n = i[0];
            din = 8'(i * 37);
            tick();
            chk("R8 deselected no capture", out_valid, 0);
            chk("R8 deselected no abort", abort_pulse, 0);
        end
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_stream();
        t_stall();
        t_abort_w2r();
        t_abort_r2w();
        t_deselected();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule